// File: doc/BRIEF.md
# Masked Alarm and Periodic Tick Interrupt Unit

This unit watches a running clock-and-calendar value held in packed BCD and raises an alarm event when it agrees with a programmed alarm value. Each of the twelve BCD digits (six for time, six for the calendar) can be left out of the comparison through its own mask bit. The two hour-digit masks are only honoured while the clock runs in 24-hour mode. An alarm event fires once, on the cycle the comparison starts to hold, and not again until it has stopped holding and then holds once more.

Alongside the alarm, a tick generator counts pulses of a 32.768 kHz clock enable. It produces a periodic event every 2^-n seconds, where n is a 3-bit select code from 0 (one second) to 7 (1/128 second). Each of the two events sets a sticky status flag that software clears by writing one to it. A single interrupt-and-wake line is high while any flag is set and its enable bit is on. The time and calendar values come from the timekeeping logic outside this unit. Configuration arrives as single-cycle register writes.

Register writes are plain single-cycle strobes with no back-pressure: every write presented with `wr_en` high is taken on that clock edge. The time and calendar inputs are level-sampled on every clock.

Top module: `alarm_tick_irq`

## Requirements
- R1: Write addresses are: 0 alarm time, 1 alarm calendar, 2 time mask, 3 calendar mask, 4 tick select (bits 2:0), 5 interrupt enables (bit 0 alarm, bit 1 tick), 6 status clear. The time word packs seconds units in 3:0, seconds tens in 6:4, minutes units in 11:8, minutes tens in 14:12, hours units in 19:16 and hours tens in 21:20. The calendar word packs day units in 3:0, day tens in 5:4, month units in 11:8, month tens in 12, year units in 19:16 and year tens in 23:20. When every unmasked digit of both words equals the alarm registers, status bit 0 is set one clock later.
- R2: Time mask bit k removes one time digit from the comparison, with k=0 for seconds units, then seconds tens, minutes units, minutes tens, hours units, and k=5 for hours tens.
- R3: Calendar mask bit k removes one calendar digit, with k=0 for day units, then day tens, month units, month tens, year units, and k=5 for year tens.
- R4: With `hour24` low, time mask bits 4 and 5 have no effect and the hour digits are always compared.
- R5: The alarm flag sets only on the cycle the match begins. After it is cleared, it stays clear while the match keeps holding.
- R6: With tick select n, a tick sets status bit 1 on the 32768/2^n-th clock-enable pulse after the count restarts.
- R7: Any write to the tick select register restarts the count from zero, and no tick occurs on that cycle.
- R8: Writing address 6 clears each status bit whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R9: When a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R10: `irq_wake` equals (status bit 0 AND enable bit 0) OR (status bit 1 AND enable bit 1).
- R11: While `rst_n` is low, both status bits and `irq_wake` are 0, and all alarm, mask, select and enable registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_32k | input | 1 | One-cycle pulse at 32.768 kHz |
| hour24 | input | 1 | 1 selects 24-hour mode, 0 selects 12-hour mode |
| cur_time | input | 22 | Current packed BCD time |
| cur_cal | input | 24 | Current packed BCD calendar |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 24 | Register write data |
| irq_wake | output | 1 | Interrupt and wake request |
| status | output | 2 | Sticky flags: bit 0 alarm, bit 1 tick |

## Verification
A wrong comparator or mask decode shows up on `status[0]` on the clock after the offending time value is applied. A broken edge detector shows up as a flag that comes back straight after a clear. A miscounted tick divider only becomes visible when the tick flag rises early or late, which can be up to a full second of enable pulses after the fault. The bench therefore measures the tick at both the shortest and the longest period. A reference model compares both flags and the interrupt line on every clock, so any divergence is reported within one cycle of reaching the ports.

// File: rtl/atk_pkg.sv
package atk_pkg;
  localparam int NDIG       = 6;
  localparam int DIG_STRIDE = 4;
  localparam int TIME_W     = 22;
  localparam int CAL_W      = 24;
  localparam int MASK_W     = NDIG;
  localparam int SEL_W      = 3;
  localparam int NSRC       = 2;
  localparam int SRC_ALARM  = 0;
  localparam int SRC_TICK   = 1;
  localparam int HOUR_LO    = 4;

  typedef enum logic [2:0] {
    RA_ALM_TIME = 3'd0,
    RA_ALM_CAL  = 3'd1,
    RA_TMASK    = 3'd2,
    RA_CMASK    = 3'd3,
    RA_TICK_SEL = 3'd4,
    RA_IRQ_EN   = 3'd5,
    RA_STATUS   = 3'd6
  } reg_addr_e;

  // width of time digit i (units/tens for sec, min, hour)
  function automatic int time_dig_w(input int i);
    case (i)
      1, 3:    return 3;
      5:       return 2;
      default: return 4;
    endcase
  endfunction

  // width of calendar digit i (units/tens for day, month, year)
  function automatic int cal_dig_w(input int i);
    case (i)
      1:       return 2;
      3:       return 1;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/alarm_match.sv
module alarm_match import atk_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hour24,
  input  logic [TIME_W-1:0] cur_time,
  input  logic [CAL_W-1:0]  cur_cal,
  input  logic [TIME_W-1:0] alm_time,
  input  logic [CAL_W-1:0]  alm_cal,
  input  logic [MASK_W-1:0] tmask,
  input  logic [MASK_W-1:0] cmask,
  output logic              alarm_evt
);
  logic [MASK_W-1:0] tmask_eff;
  logic [NDIG-1:0]   t_hit, c_hit;
  logic              match, match_q;

  // hour masks only honoured in 24-hour mode
  always_comb begin
    tmask_eff = tmask;
    if (!hour24) tmask_eff[MASK_W-1:HOUR_LO] = '0;
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    localparam int OFF = g * DIG_STRIDE;
    localparam int TWD = time_dig_w(g);
    localparam int CWD = cal_dig_w(g);
    assign t_hit[g] = tmask_eff[g] | (cur_time[OFF +: TWD] == alm_time[OFF +: TWD]);
    assign c_hit[g] = cmask[g]     | (cur_cal[OFF +: CWD]  == alm_cal[OFF +: CWD]);
  end

  assign match = (&t_hit) & (&c_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match;
  end

  assign alarm_evt = match & ~match_q;

  // R5: an event marks the start of a match, so two in a row cannot occur
  a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> !alarm_evt);
endmodule

// File: rtl/tick_gen.sv
module tick_gen import atk_pkg::*; #(
  parameter int CLK_HZ = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_evt
);
  localparam int CNT_W = $clog2(CLK_HZ);

  logic [CNT_W-1:0] cnt, lim;

  assign lim      = CNT_W'((CLK_HZ >> sel) - 1);
  assign tick_evt = ce & ~restart & (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (ce) begin
      if (cnt >= lim) cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end
  end

  // R7: no tick on the restart cycle, and the count is back to zero after it
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (!tick_evt ##1 (cnt == '0)));
  // R6: shortest period spans many enables, so ticks never come back to back
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> !tick_evt);
endmodule

// File: rtl/irq_status.sv
module irq_status import atk_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flag,
  output logic            irq
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[s] <= 1'b0;
      else if (evt[s]) flag[s] <= 1'b1;
      else if (clr[s]) flag[s] <= 1'b0;
    end
  end

  assign irq = |(flag & en);

  // R9: a set event always leaves its flag set, even with a clear pending
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SRC_ALARM] |=> flag[SRC_ALARM]);
  // R8: a clear without a competing event drops the flag
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[SRC_TICK] && !evt[SRC_TICK]) |=> !flag[SRC_TICK]);
  // R10: the request line needs a pending flag
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag != '0));
endmodule

// File: rtl/alarm_tick_irq.sv
module alarm_tick_irq import atk_pkg::*; #(
  parameter int CLK_HZ = 32768,
  parameter int DATA_W = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_32k,
  input  logic              hour24,
  input  logic [TIME_W-1:0] cur_time,
  input  logic [CAL_W-1:0]  cur_cal,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_wake,
  output logic [NSRC-1:0]   status
);
  logic [TIME_W-1:0] alm_time;
  logic [CAL_W-1:0]  alm_cal;
  logic [MASK_W-1:0] tmask, cmask;
  logic [SEL_W-1:0]  tick_sel;
  logic [NSRC-1:0]   irq_en;
  logic              wr_tsel, wr_stat, alarm_evt, tick_evt;
  logic [NSRC-1:0]   clr;

  assign wr_tsel = wr_en && (wr_addr == ADDR_W'(RA_TICK_SEL));
  assign wr_stat = wr_en && (wr_addr == ADDR_W'(RA_STATUS));
  assign clr     = wr_stat ? wr_data[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_time <= '0;
      alm_cal  <= '0;
      tmask    <= '0;
      cmask    <= '0;
      tick_sel <= '0;
      irq_en   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(RA_ALM_TIME): alm_time <= wr_data[TIME_W-1:0];
        ADDR_W'(RA_ALM_CAL):  alm_cal  <= wr_data[CAL_W-1:0];
        ADDR_W'(RA_TMASK):    tmask    <= wr_data[MASK_W-1:0];
        ADDR_W'(RA_CMASK):    cmask    <= wr_data[MASK_W-1:0];
        ADDR_W'(RA_TICK_SEL): tick_sel <= wr_data[SEL_W-1:0];
        ADDR_W'(RA_IRQ_EN):   irq_en   <= wr_data[NSRC-1:0];
        default: ;
      endcase
    end
  end

  alarm_match u_match (
    .clk(clk), .rst_n(rst_n), .hour24(hour24),
    .cur_time(cur_time), .cur_cal(cur_cal),
    .alm_time(alm_time), .alm_cal(alm_cal),
    .tmask(tmask), .cmask(cmask), .alarm_evt(alarm_evt)
  );

  tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .ce(ce_32k), .restart(wr_tsel),
    .sel(tick_sel), .tick_evt(tick_evt)
  );

  irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt({tick_evt, alarm_evt}),
    .clr(clr), .en(irq_en), .flag(status), .irq(irq_wake)
  );

  // R11: registers hold their reset values on the cycle after reset
  a_r11_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && irq_wake == 1'b0));
endmodule

// File: tb/alarm_tick_irq_tb.sv
module alarm_tick_irq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, ce, h24, wr_en;
  logic [2:0]  wa;
  logic [23:0] wd;
  logic [21:0] ct;
  logic [23:0] cc;
  logic        irq;
  logic [1:0]  st;

  int tests = 0, fails = 0;

  alarm_tick_irq u_dut (
    .clk(clk), .rst_n(rst_n), .ce_32k(ce), .hour24(h24),
    .cur_time(ct), .cur_cal(cc), .wr_en(wr_en), .wr_addr(wa), .wr_data(wd),
    .irq_wake(irq), .status(st)
  );

  // ---------------- behavioural reference model ----------------
  int m_at, m_ac, m_tm, m_cm, m_sel, m_en, m_fl, m_prev, m_cnt;
  int m_match, m_tmeff, m_aevt, m_tevt, m_clr, m_msk;
  int twd[6] = '{4, 3, 4, 3, 4, 2};
  int cwd[6] = '{4, 2, 4, 1, 4, 4};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_at = 0; m_ac = 0; m_tm = 0; m_cm = 0; m_sel = 0; m_en = 0;
      m_fl = 0; m_prev = 0; m_cnt = 0;
    end else begin
      m_tmeff = h24 ? m_tm : (m_tm & 'h0F);
      m_match = 1;
      for (int i = 0; i < 6; i++) begin
        m_msk = (1 << twd[i]) - 1;
        if (((m_tmeff >> i) & 1) == 0 &&
            ((int'(ct) >> (4*i)) & m_msk) != ((m_at >> (4*i)) & m_msk)) m_match = 0;
        m_msk = (1 << cwd[i]) - 1;
        if (((m_cm >> i) & 1) == 0 &&
            ((int'(cc) >> (4*i)) & m_msk) != ((m_ac >> (4*i)) & m_msk)) m_match = 0;
      end
      m_aevt = (m_match == 1 && m_prev == 0) ? 1 : 0;
      m_prev = m_match;
      m_tevt = 0;
      if (wr_en && wa == 3'd4) m_cnt = 0;
      else if (ce) begin
        if (m_cnt == (32768 >> m_sel) - 1) begin m_cnt = 0; m_tevt = 1; end
        else m_cnt = m_cnt + 1;
      end
      m_clr = (wr_en && wa == 3'd6) ? int'(wd[1:0]) : 0;
      m_fl  = ((m_fl & ~m_clr) | (m_tevt << 1) | m_aevt) & 3;
      if (wr_en) begin
        case (wa)
          3'd0: m_at  = int'(wd[21:0]);
          3'd1: m_ac  = int'(wd);
          3'd2: m_tm  = int'(wd[5:0]);
          3'd3: m_cm  = int'(wd[5:0]);
          3'd4: m_sel = int'(wd[2:0]);
          3'd5: m_en  = int'(wd[1:0]);
          default: ;
        endcase
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (st[0] !== m_fl[0]) begin
        fails++;
        $display("FAIL R1 alarm flag vs model: got %0b exp %0b at %0t", st[0], m_fl[0], $time);
      end
      tests++;
      if (st[1] !== m_fl[1]) begin
        fails++;
        $display("FAIL R6 tick flag vs model: got %0b exp %0b at %0t", st[1], m_fl[1], $time);
      end
      tests++;
      if (irq !== ((m_fl[0] & m_en[0]) | (m_fl[1] & m_en[1]))) begin
        fails++;
        $display("FAIL R10 irq vs model: got %0b exp %0b at %0t", irq,
                 (m_fl[0] & m_en[0]) | (m_fl[1] & m_en[1]), $time);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); wr_en = 1'b1; wa = a; wd = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; h24 = 1'b1; wr_en = 1'b0; wa = '0; wd = '0;
    ct = 22'h010203; cc = 24'h010101;
    step(4);
    chk(int'(st), 0, "R11 status in reset");
    chk(int'(irq), 0, "R11 irq in reset");
    rst_n = 1'b1;
    step(1);

    // R1: full match of time and calendar
    wr(3'd5, 24'h1);
    wr(3'd0, 24'h123456);
    wr(3'd1, 24'h250315);
    ct = 22'h123456; cc = 24'h250315;
    step(1);
    chk(int'(st[0]), 1, "R1 alarm on full match");
    chk(int'(irq), 1, "R10 irq from alarm");

    // R8: zero data leaves flag, one clears
    wr(3'd6, 24'h0);
    chk(int'(st[0]), 1, "R8 zero write keeps flag");
    wr(3'd6, 24'h1);
    chk(int'(st[0]), 0, "R8 one write clears flag");
    // R5: match still holds, flag stays clear
    step(3);
    chk(int'(st[0]), 0, "R5 no re-set during held match");

    // R9: match begins in the same cycle as a clear write
    ct = 22'h123455;
    step(1);
    wr_en = 1'b1; wa = 3'd6; wd = 24'h1; ct = 22'h123456;
    step(1);
    wr_en = 1'b0;
    chk(int'(st[0]), 1, "R9 set wins over clear");

    // R2: seconds digits masked
    ct = 22'h120000;
    step(1);
    wr(3'd6, 24'h3);
    wr(3'd2, 24'h03);
    ct = 22'h123419;
    step(1);
    chk(int'(st[0]), 1, "R2 masked seconds match");
    wr(3'd6, 24'h1);
    ct = 22'h123519;
    step(2);
    chk(int'(st[0]), 0, "R2 minutes units still compared");

    // R3: year digits masked
    wr(3'd2, 24'h00);
    wr(3'd3, 24'h30);
    ct = 22'h123456; cc = 24'h990315;
    step(1);
    chk(int'(st[0]), 1, "R3 masked year match");

    // R4: hour masks ignored in 12-hour mode
    cc = 24'h250315; ct = 22'h000000;
    wr(3'd3, 24'h00);
    wr(3'd6, 24'h1);
    wr(3'd2, 24'h30);
    h24 = 1'b0; ct = 22'h003456;
    step(2);
    chk(int'(st[0]), 0, "R4 hour mask ignored in 12h");
    h24 = 1'b1;
    step(1);
    chk(int'(st[0]), 1, "R4 hour mask honoured in 24h");

    // R6: tick at select 7 -> 256 enables
    wr(3'd6, 24'h3);
    wr(3'd5, 24'h2);
    ce = 1'b1;
    wr(3'd4, 24'h7);
    step(255);
    chk(int'(st[1]), 0, "R6 no tick before 256 enables");
    step(1);
    chk(int'(st[1]), 1, "R6 tick at 256 enables");
    chk(int'(irq), 1, "R10 irq from tick");

    // R7: rewrite restarts the count
    wr(3'd6, 24'h2);
    step(100);
    wr(3'd4, 24'h7);
    step(255);
    chk(int'(st[1]), 0, "R7 restart delays tick");
    step(1);
    chk(int'(st[1]), 1, "R7 tick 256 after restart");

    // R6: select 0 -> 32768 enables
    wr(3'd6, 24'h2);
    wr(3'd4, 24'h0);
    step(32767);
    chk(int'(st[1]), 0, "R6 one-second tick not early");
    step(1);
    chk(int'(st[1]), 1, "R6 one-second tick on time");

    // R10: enables gate the request
    wr(3'd5, 24'h0);
    chk(int'(irq), 0, "R10 irq masked by enables");
    wr(3'd5, 24'h2);
    chk(int'(irq), 1, "R10 tick enable restores irq");
    ce = 1'b0;
    step(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule